// File: doc/BRIEF.md
# Serial Port Control and Status Register Bank

This block is the register front end of a FIFO-based serial port. A host bus reaches it through single-cycle read and write strobes carrying a byte offset. It holds the mode, bit-rate, control, port and FIFO-control settings. Each setting register keeps only the bits the port implements. It also holds a transmit data byte that the transmit path picks up.

The block keeps five status flags: transmit end, transmit data empty, break, receive FIFO full and data ready. The receive path and the break detector set these flags with one-cycle event pulses. Software clears a flag by writing a zero to its bit in the status register. Writing a one leaves the flag as it is.

The block drives two interrupt lines. The transmit interrupt follows bit 7 of the control register. The receive interrupt is a sticky line. A receive-full event raises it when receive interrupts are enabled. Software withdraws it through the status or control register. An event that lands in the same cycle as a clearing write always wins, so no event is lost.

Top module: `serctl_regbank`

## Requirements
- R1: After reset, reads return the following values: mode 0x00 at offset 0x00, bit-rate 0xFF at offset 0x02, control 0x20 at offset 0x04, transmit data 0x00 at offset 0x06, status 0x60 at offset 0x08, FIFO control 0x0000 at offset 0x0A and port 0x00 at offset 0x0C. Both interrupt outputs are low after reset.
- R2: Written values are masked before they are stored. The mode register keeps the bits in mask 0x7B, the control register keeps mask 0xFA and the port register keeps mask 0xF3. The bit-rate register keeps all 8 bits and the FIFO control register keeps all 16 bits. The transmit data register keeps the low 8 bits.
- R3: The status register has the following layout: transmit end at bit 6, transmit data empty at bit 5, break at bit 4, receive full at bit 1 and data ready at bit 0. All other bits read as zero. Writing 0 to one of these five bits clears that flag.
- R4: Writing 1 to a flag bit in the status register leaves that flag unchanged.
- R5: A pulse on `brk_evt` sets the break flag. A pulse on `rx_full_evt` sets the receive-full flag. A pulse on `rx_ready_evt` sets the data-ready flag. An event wins over a clearing status write in the same cycle.
- R6: A write to the transmit data register clears the transmit-data-empty flag.
- R7: A control register write with bit 5 equal to 0 sets the transmit-end flag. A control write with bit 5 equal to 1 leaves that flag unchanged.
- R8: `tx_irq` equals bit 7 of the stored control register.
- R9: `rx_irq` rises the cycle after an `rx_full_evt` pulse while control bit 6 is set. Either of two writes drops it: a status write with bit 1 or bit 0 equal to 0, or a control write with bit 6 equal to 0. A raising event in the same cycle as such a write keeps it high.
- R10: A read from an offset other than the seven listed returns zero. A write to such an offset changes no register, flag or interrupt.
- R11: `rdata` carries the selected register in the cycle after `rd_en` is sampled high. It is zero in a cycle after `rd_en` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 5 | Byte offset of the access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rx_full_evt | input | 1 | Receive FIFO reached its trigger level |
| rx_ready_evt | input | 1 | Receive data is waiting |
| brk_evt | input | 1 | Break condition detected |
| tx_byte | output | 8 | Stored transmit data byte |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The masked registers are each swept over all 256 byte values. This shows up any bit that the mask should keep or drop.

The status clear logic is swept over all 256 write values, starting each time from a state with every flag set. This separates write-zero-clears from write-one-keeps on each flag, and it shows the unused bits staying zero.

Directed sequences pair each event with a clearing write in the same cycle, to check that the event wins. They also check each way of withdrawing the receive interrupt.

A sweep over every unmapped offset checks that reads return zero and that writes leave all state alone.

// File: rtl/serctl_pkg.sv
// Package: shared offsets, write masks, reset values and status bit
// positions for the serial control/status register bank.
package serctl_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] OFS_MODE = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_RATE = 5'h02;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_TXD  = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_FCTL = 5'h0A;
    localparam logic [ADDR_W-1:0] OFS_PORT = 5'h0C;

    localparam logic [7:0] MASK_MODE = 8'h7B;
    localparam logic [7:0] MASK_CTRL = 8'hFA;
    localparam logic [7:0] MASK_PORT = 8'hF3;

    localparam logic [7:0] RST_RATE = 8'hFF;
    localparam logic [7:0] RST_CTRL = 8'h20;

    // Status bit positions (software-visible layout).
    localparam int SB_TEND = 6;
    localparam int SB_TDE  = 5;
    localparam int SB_BRK  = 4;
    localparam int SB_RDF  = 1;
    localparam int SB_DR   = 0;

    // Control bit positions.
    localparam int CB_TXIE = 7;
    localparam int CB_RXIE = 6;
    localparam int CB_TXEN = 5;
endpackage

// File: rtl/serctl_cfg.sv
// Module: serctl_cfg
// Decodes bus writes and holds the setting registers: mode, bit-rate,
// control, port, FIFO control and transmit data. Each register applies
// its write mask when it stores a value.
// Assumes: wr_en lasts one cycle per access, and addr is a byte offset.
module serctl_cfg
    import serctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [7:0]        mode_q,
    output logic [7:0]        rate_q,
    output logic [7:0]        ctrl_q,
    output logic [7:0]        port_q,
    output logic [DATA_W-1:0] fctl_q,
    output logic [7:0]        txd_q,
    output logic              ctrl_wr,
    output logic              stat_wr,
    output logic              txd_wr
);
    logic mode_wr, rate_wr, fctl_wr, port_wr;

    // Write decode: one strobe per mapped offset.
    always_comb begin
        mode_wr = wr_en && (addr == OFS_MODE);
        rate_wr = wr_en && (addr == OFS_RATE);
        ctrl_wr = wr_en && (addr == OFS_CTRL);
        txd_wr  = wr_en && (addr == OFS_TXD);
        stat_wr = wr_en && (addr == OFS_STAT);
        fctl_wr = wr_en && (addr == OFS_FCTL);
        port_wr = wr_en && (addr == OFS_PORT);
    end

    // Setting registers with masks applied on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            rate_q <= RST_RATE;
            ctrl_q <= RST_CTRL;
            port_q <= '0;
            fctl_q <= '0;
            txd_q  <= '0;
        end else begin
            if (mode_wr) mode_q <= wdata[7:0] & MASK_MODE;
            if (rate_wr) rate_q <= wdata[7:0];
            if (ctrl_wr) ctrl_q <= wdata[7:0] & MASK_CTRL;
            if (port_wr) port_q <= wdata[7:0] & MASK_PORT;
            if (fctl_wr) fctl_q <= wdata;
            if (txd_wr)  txd_q  <= wdata[7:0];
        end
    end

    // R10: a write to an unmapped offset leaves the setting registers alone
    a_r10_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_wr && !rate_wr && !ctrl_wr && !txd_wr && !stat_wr && !fctl_wr && !port_wr)
        |=> ($stable(mode_q) && $stable(rate_q) && $stable(ctrl_q) && $stable(port_q)
             && $stable(fctl_q) && $stable(txd_q)));
endmodule

// File: rtl/serctl_flags.sv
// Module: serctl_flags
// Holds the five status flags. A status write clears each flag whose
// bit is written as zero. Events from the receive path and the break
// detector set flags and win over a clear in the same cycle.
// Assumes: the strobes come from serctl_cfg and wdata is the bus data.
module serctl_flags
    import serctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_wr,
    input  logic       ctrl_wr,
    input  logic       txd_wr,
    input  logic [7:0] wbyte,
    input  logic       rx_full_evt,
    input  logic       rx_ready_evt,
    input  logic       brk_evt,
    output logic [7:0] stat_byte
);
    logic tend_q, tde_q, brk_q, rdf_q, dr_q;

    // Flag update: the clear is applied first, then set terms override it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tend_q <= 1'b1;
            tde_q  <= 1'b1;
            brk_q  <= 1'b0;
            rdf_q  <= 1'b0;
            dr_q   <= 1'b0;
        end else begin
            if (stat_wr && !wbyte[SB_TEND]) tend_q <= 1'b0;
            if (ctrl_wr && !wbyte[CB_TXEN]) tend_q <= 1'b1;
            if ((stat_wr && !wbyte[SB_TDE]) || txd_wr) tde_q <= 1'b0;
            if (stat_wr && !wbyte[SB_BRK]) brk_q <= 1'b0;
            if (brk_evt) brk_q <= 1'b1;
            if (stat_wr && !wbyte[SB_RDF]) rdf_q <= 1'b0;
            if (rx_full_evt) rdf_q <= 1'b1;
            if (stat_wr && !wbyte[SB_DR]) dr_q <= 1'b0;
            if (rx_ready_evt) dr_q <= 1'b1;
        end
    end

    // Status byte assembly in the software-visible layout.
    always_comb begin
        stat_byte          = '0;
        stat_byte[SB_TEND] = tend_q;
        stat_byte[SB_TDE]  = tde_q;
        stat_byte[SB_BRK]  = brk_q;
        stat_byte[SB_RDF]  = rdf_q;
        stat_byte[SB_DR]   = dr_q;
    end

    // R3: a zero written with no competing event clears the flag
    a_r3_brk_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !wbyte[SB_BRK] && !brk_evt) |=> !stat_byte[SB_BRK]);
    a_r3_dr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !wbyte[SB_DR] && !rx_ready_evt) |=> !stat_byte[SB_DR]);
    // R4: a one written leaves the flag as it was
    a_r4_brk_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wbyte[SB_BRK] && !brk_evt) |=> (stat_byte[SB_BRK] == $past(stat_byte[SB_BRK])));
    // R5: events win over any clear
    a_r5_brk_event: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> stat_byte[SB_BRK]);
    a_r5_rdf_event: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full_evt |=> stat_byte[SB_RDF]);
    // R6: a transmit data write empties the data-empty flag
    a_r6_txd_clears_tde: assert property (@(posedge clk) disable iff (!rst_n)
        txd_wr |=> !stat_byte[SB_TDE]);
    // R7: a control write with transmit disabled sets transmit end
    a_r7_txoff_sets_tend: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wbyte[CB_TXEN]) |=> stat_byte[SB_TEND]);
endmodule

// File: rtl/serctl_rxirq.sv
// Module: serctl_rxirq
// Sticky receive interrupt. A receive-full event raises it while
// receive interrupts are enabled. Clearing status or control writes
// withdraw it, but a raise in the same cycle wins.
// Assumes: rxie is the stored control bit 6.
module serctl_rxirq
    import serctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_full_evt,
    input  logic       rxie,
    input  logic       stat_wr,
    input  logic       ctrl_wr,
    input  logic [7:0] wbyte,
    output logic       rx_irq
);
    logic raise, drop;

    // Raise and drop terms.
    always_comb begin
        raise = rx_full_evt && rxie;
        drop  = (stat_wr && (!wbyte[SB_RDF] || !wbyte[SB_DR]))
             || (ctrl_wr && !wbyte[CB_RXIE]);
    end

    // Interrupt state: a raise takes priority over a drop.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_irq <= 1'b0;
        else if (raise)  rx_irq <= 1'b1;
        else if (drop)   rx_irq <= 1'b0;
    end

    // R9: the raise is seen one cycle later
    a_r9_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full_evt && rxie) |=> rx_irq);
    // R9: a drop with no raise withdraws the line
    a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !wbyte[SB_DR] && !rx_full_evt) |=> !rx_irq);
    // R10: with no event and no bus write the line holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_full_evt && !stat_wr && !ctrl_wr) |=> $stable(rx_irq));
endmodule

// File: rtl/serctl_regbank.sv
// Module: serctl_regbank (top)
// Control and status register bank for a FIFO serial port. It ties
// together write decode and settings, the status flags and the receive
// interrupt, and it provides a registered read path.
// Assumes: single-cycle rd_en/wr_en strobes and one-cycle event pulses.
module serctl_regbank
    import serctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rx_full_evt,
    input  logic              rx_ready_evt,
    input  logic              brk_evt,
    output logic [7:0]        tx_byte,
    output logic              tx_irq,
    output logic              rx_irq
);
    logic [7:0]        mode_q, rate_q, ctrl_q, port_q, stat_byte;
    logic [DATA_W-1:0] fctl_q;
    logic              ctrl_wr, stat_wr, txd_wr;
    logic [DATA_W-1:0] rd_mux;

    serctl_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .mode_q(mode_q), .rate_q(rate_q), .ctrl_q(ctrl_q), .port_q(port_q),
        .fctl_q(fctl_q), .txd_q(tx_byte),
        .ctrl_wr(ctrl_wr), .stat_wr(stat_wr), .txd_wr(txd_wr)
    );

    serctl_flags u_flags (
        .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .ctrl_wr(ctrl_wr),
        .txd_wr(txd_wr), .wbyte(wdata[7:0]), .rx_full_evt(rx_full_evt),
        .rx_ready_evt(rx_ready_evt), .brk_evt(brk_evt), .stat_byte(stat_byte)
    );

    serctl_rxirq u_rxirq (
        .clk(clk), .rst_n(rst_n), .rx_full_evt(rx_full_evt),
        .rxie(ctrl_q[CB_RXIE]), .stat_wr(stat_wr), .ctrl_wr(ctrl_wr),
        .wbyte(wdata[7:0]), .rx_irq(rx_irq)
    );

    // Transmit interrupt follows the stored enable bit.
    assign tx_irq = ctrl_q[CB_TXIE];

    // Read select: unmapped offsets give zero.
    always_comb begin
        rd_mux = '0;
        case (addr)
            OFS_MODE: rd_mux[7:0] = mode_q;
            OFS_RATE: rd_mux[7:0] = rate_q;
            OFS_CTRL: rd_mux[7:0] = ctrl_q;
            OFS_TXD:  rd_mux[7:0] = tx_byte;
            OFS_STAT: rd_mux[7:0] = stat_byte;
            OFS_FCTL: rd_mux      = fctl_q;
            OFS_PORT: rd_mux[7:0] = port_q;
            default:  rd_mux      = '0;
        endcase
    end

    // Registered read data, zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
        else            rdata <= '0;
    end

    // R8: a control write with bit 7 set raises the transmit interrupt
    a_r8_txirq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[CB_TXIE]) |=> tx_irq);
    // R11: no read strobe means zero read data next cycle
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));
endmodule

// File: tb/tb_serctl_regbank.sv
module tb_serctl_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rx_full_evt = 1'b0, rx_ready_evt = 1'b0, brk_evt = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_irq, rx_irq;
    int          n_chk = 0, n_bad = 0;
    logic [15:0] got;

    always #10 clk = ~clk;

    serctl_regbank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_full_evt(rx_full_evt),
        .rx_ready_evt(rx_ready_evt), .brk_evt(brk_evt), .tx_byte(tx_byte),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic events(input logic f, input logic r, input logic b);
        @(negedge clk); rx_full_evt = f; rx_ready_evt = r; brk_evt = b;
        @(negedge clk); rx_full_evt = 1'b0; rx_ready_evt = 1'b0; brk_evt = 1'b0;
    endtask

    function automatic bit mapped(input logic [4:0] a);
        return a inside {5'h00, 5'h02, 5'h04, 5'h06, 5'h08, 5'h0A, 5'h0C};
    endfunction

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset values
        rd(5'h00, got); chk("R1 mode", got, 16'h0000);
        rd(5'h02, got); chk("R1 rate", got, 16'h00FF);
        rd(5'h04, got); chk("R1 ctrl", got, 16'h0020);
        rd(5'h06, got); chk("R1 txd", got, 16'h0000);
        rd(5'h08, got); chk("R1 stat", got, 16'h0060);
        rd(5'h0A, got); chk("R1 fctl", got, 16'h0000);
        rd(5'h0C, got); chk("R1 port", got, 16'h0000);
        chk("R1 irqs", {14'h0, tx_irq, rx_irq}, 16'h0);
        // R11 idle read data
        @(negedge clk); chk("R11 idle", rdata, 16'h0000);

        // R2 mask sweeps, R8 tx_irq follows control bit 7
        for (int v = 0; v < 256; v++) begin
            wr(5'h00, 16'hAB00 | v[15:0]); rd(5'h00, got); chk("R2 mode", got, 16'(v & 8'h7B));
            wr(5'h0C, v[15:0]); rd(5'h0C, got); chk("R2 port", got, 16'(v & 8'hF3));
            wr(5'h02, v[15:0]); rd(5'h02, got); chk("R2 rate", got, 16'(v));
            wr(5'h06, v[15:0]); chk("R2 txbyte", {8'h0, tx_byte}, 16'(v));
            wr(5'h04, v[15:0]); rd(5'h04, got); chk("R2 ctrl", got, 16'(v & 8'hFA));
            chk("R8 tx_irq", {15'h0, tx_irq}, {15'h0, v[7]});
            wr(5'h0A, 16'(v * 257 ^ 16'h5A3C)); rd(5'h0A, got);
            chk("R2 fctl", got, 16'(v * 257 ^ 16'h5A3C));
        end

        // R3/R4 clear-on-zero sweep from an all-set state
        for (int v = 0; v < 256; v++) begin
            do_reset();
            events(1'b1, 1'b1, 1'b1);
            wr(5'h08, v[15:0]);
            rd(5'h08, got); chk("R3 R4 stat sweep", got, 16'(v & 8'h73));
        end

        // R6 transmit data write clears data-empty
        do_reset();
        wr(5'h06, 16'h0041); rd(5'h08, got); chk("R6 tde", got, 16'h0040);
        // R7 transmit end set by a control write with transmit disabled
        wr(5'h08, 16'h0000); rd(5'h08, got); chk("R3 clear all", got, 16'h0000);
        wr(5'h04, 16'h0020); rd(5'h08, got); chk("R7 txen kept", got, 16'h0000);
        wr(5'h04, 16'h0000); rd(5'h08, got); chk("R7 tend set", got, 16'h0040);

        // R5 event wins over clearing write in the same cycle
        @(negedge clk); addr = 5'h08; wdata = 16'h0000; wr_en = 1'b1;
        brk_evt = 1'b1; rx_ready_evt = 1'b1;
        @(negedge clk); wr_en = 1'b0; brk_evt = 1'b0; rx_ready_evt = 1'b0;
        rd(5'h08, got); chk("R5 event priority", got, 16'h0011);

        // R9 receive interrupt
        do_reset();
        events(1'b1, 1'b0, 1'b0); chk("R9 no raise when disabled", {15'h0, rx_irq}, 16'h0);
        wr(5'h04, 16'h0060);
        events(1'b1, 1'b0, 1'b0); chk("R9 raise", {15'h0, rx_irq}, 16'h1);
        wr(5'h08, 16'h00FF); chk("R9 keep on ones", {15'h0, rx_irq}, 16'h1);
        wr(5'h08, 16'h00FE); chk("R9 drop via bit0", {15'h0, rx_irq}, 16'h0);
        events(1'b1, 1'b0, 1'b0);
        wr(5'h08, 16'h00FD); chk("R9 drop via bit1", {15'h0, rx_irq}, 16'h0);
        events(1'b1, 1'b0, 1'b0);
        wr(5'h04, 16'h0020); chk("R9 drop via ctrl", {15'h0, rx_irq}, 16'h0);
        wr(5'h04, 16'h0060);
        @(negedge clk); addr = 5'h08; wdata = 16'h0000; wr_en = 1'b1; rx_full_evt = 1'b1;
        @(negedge clk); wr_en = 1'b0; rx_full_evt = 1'b0;
        chk("R9 raise wins", {15'h0, rx_irq}, 16'h1);

        // R10 unmapped offsets: reads zero, writes without effect
        do_reset();
        wr(5'h04, 16'h00E0);
        events(1'b1, 1'b0, 1'b0);
        for (int a = 0; a < 32; a++) begin
            if (!mapped(a[4:0])) begin
                wr(a[4:0], 16'h0000);
                rd(a[4:0], got); chk("R10 unmapped read", got, 16'h0000);
            end
        end
        rd(5'h00, got); chk("R10 mode", got, 16'h0000);
        rd(5'h02, got); chk("R10 rate", got, 16'h00FF);
        rd(5'h04, got); chk("R10 ctrl", got, 16'h00E0);
        rd(5'h08, got); chk("R10 stat", got, 16'h0062);
        rd(5'h0A, got); chk("R10 fctl", got, 16'h0000);
        rd(5'h0C, got); chk("R10 port", got, 16'h0000);
        chk("R10 irqs", {14'h0, tx_irq, rx_irq}, 16'h3);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule